// File: doc/BRIEF.md
# Serial Waveform Command Parser

This block sits behind a UART receiver and turns a stream of ASCII bytes into waveform-generator commands. Each byte arrives with a one-cycle valid strobe. A command line starts with a two-letter mnemonic. The mnemonic picks square, sine, triangle or sawtooth output, switches the output off, or asks for help. Up to two unsigned decimal numbers may follow the mnemonic. The first number is always the frequency and the second is always the amplitude, so an amplitude can only be given after a frequency.

When a carriage return or line feed ends a non-empty line, the parser emits a one-cycle command strobe. With it come the waveform code, a presence flag and value for each argument, and an error flag. A bad line still produces a strobe, but with the error flag set and no parameters. The parser then returns to idle, so the next line is parsed on its own. Converting frequency to a phase increment is left to the consumer.

Top module: `wave_cmd_parser`

## Requirements
- R1: Mnemonics decode to codes on `cmd_wave`: OF=0 (output off), SQ=1 (square), SI=2 (sine), TR=3 (triangle), SA=4 (sawtooth), ??=5 (help); an error strobe carries code 7.
- R2: Letters in a mnemonic match regardless of case.
- R3: The terminator byte is CR (0x0D) or LF (0x0A). `cmd_valid` is high for exactly one cycle, in the cycle after the edge that accepts the terminator. `rx_data` has no effect while `rx_valid` is low.
- R4: A line holding nothing, or only spaces (0x20), produces no strobe, so CR followed by LF yields a single strobe.
- R5: Fields are separated by one or more spaces, and trailing spaces are allowed. The first number sets `freq_set`=1 and `freq_val`. The second number also sets `amp_set`=1 and `amp_val`. A flag that is 0 at a strobe has its value reported as 0.
- R6: A number larger than 4294967295 saturates to 0xFFFFFFFF instead of wrapping.
- R7: An unknown two-letter mnemonic gives a strobe with `cmd_err`=1, `cmd_wave`=7, both argument flags 0 and both values 0.
- R8: A non-digit character inside a number, or a non-space non-digit character where an argument should start, is an error as in R7.
- R9: A third numeric argument is an error as in R7.
- R10: A mnemonic of one character, or of three or more characters, is an error as in R7.
- R11: After every terminator the parser is idle again, so a line that follows an error line decodes normally.
- R12: After reset, `cmd_valid`, `cmd_err`, both flags, both values and `cmd_wave` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Byte strobe from the receiver |
| rx_data | input | 8 | Received ASCII byte |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_wave | output | 3 | Waveform/command code |
| cmd_err | output | 1 | Line was malformed |
| freq_set | output | 1 | Frequency argument present |
| freq_val | output | 32 | Frequency argument value |
| amp_set | output | 1 | Amplitude argument present |
| amp_val | output | 32 | Amplitude argument value |

## Verification
The assertions assume that `rx_valid` is a clean single-cycle strobe and that `rx_data` is a defined byte whenever `rx_valid` is high. They also assume that reset is held for at least one clock edge before bytes arrive. The bench drives every byte from a task that raises `rx_valid` for exactly one cycle at the falling edge. It changes `rx_data` while `rx_valid` is low only to show that such bytes are ignored. It holds reset for several cycles before the first line. Back-to-back terminators (CR then LF) are sent on purpose, so that the one-cycle-strobe property is exercised against a second terminator arriving in idle.

// File: rtl/wfp_pkg.sv
// Package: shared codes and sizes for the waveform command parser.
// Assumes: ASCII input, with at most two numeric arguments per line.
package wfp_pkg;
    localparam int NUM_W  = 32;  // numeric argument width
    localparam int N_ARGS = 2;   // frequency, amplitude

    typedef enum logic [2:0] {
        W_OFF      = 3'd0,
        W_SQUARE   = 3'd1,
        W_SINE     = 3'd2,
        W_TRIANGLE = 3'd3,
        W_SAW      = 3'd4,
        W_HELP     = 3'd5,
        W_BAD      = 3'd7
    } wave_e;

    typedef enum logic [2:0] {
        P_IDLE,   // waiting for the first mnemonic character
        P_MN1,    // one mnemonic character seen
        P_MN2,    // two mnemonic characters seen
        P_GAP,    // between fields
        P_NUM,    // inside a number
        P_BAD     // line is bad, discard until terminator
    } pstate_e;
endpackage

// File: rtl/wfp_char_class.sv
// Module: classifies one ASCII byte and folds lower-case letters to upper case.
// Assumes: plain 8-bit ASCII; only space 0x20 is whitespace and only CR/LF end a line.
module wfp_char_class (
    input  logic [7:0] ch,
    output logic [7:0] up_ch,
    output logic       is_digit,
    output logic       is_space,
    output logic       is_term,
    output logic [3:0] digit
);
    // Case folding and character classes.
    always_comb begin
        up_ch    = (ch >= 8'h61 && ch <= 8'h7A) ? (ch - 8'h20) : ch;
        is_digit = (ch >= 8'h30 && ch <= 8'h39);
        is_space = (ch == 8'h20);
        is_term  = (ch == 8'h0D) || (ch == 8'h0A);
        digit    = ch[3:0];
    end
endmodule

// File: rtl/wfp_mnem_decode.sv
// Module: maps a two-character upper-case mnemonic to a waveform code.
// Assumes: the inputs are already case-folded.
module wfp_mnem_decode
    import wfp_pkg::*;
(
    input  logic [7:0] c0,
    input  logic [7:0] c1,
    output wave_e      code,
    output logic       known
);
    // Mnemonic lookup.
    always_comb begin
        known = 1'b1;
        case ({c0, c1})
            16'h4F46: code = W_OFF;      // OF
            16'h5351: code = W_SQUARE;   // SQ
            16'h5349: code = W_SINE;     // SI
            16'h5452: code = W_TRIANGLE; // TR
            16'h5341: code = W_SAW;      // SA
            16'h3F3F: code = W_HELP;     // ??
            default: begin
                code  = W_BAD;
                known = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/wfp_num_acc.sv
// Module: one decimal accumulation step, acc*10 + digit, saturating at all ones.
// Assumes: digit is in the range 0..9.
module wfp_num_acc #(
    parameter int W = 32
) (
    input  logic [W-1:0] acc_in,
    input  logic [3:0]   digit,
    output logic [W-1:0] acc_out
);
    localparam int WX = W + 4;
    logic [WX-1:0] wide;

    // Multiply-add in a wider word, then clamp.
    always_comb begin
        wide    = WX'(acc_in) * WX'(10) + WX'(digit);
        acc_out = (wide[WX-1:W] != '0) ? {W{1'b1}} : wide[W-1:0];
    end

    // Accumulation never wraps below the previous value.
    always_comb begin
        AST_NO_WRAP: assert (acc_out >= acc_in); // R6
    end
endmodule

// File: rtl/wave_cmd_parser.sv
// Module: line parser for two-letter waveform commands with optional frequency
// and amplitude arguments; emits one strobe per non-empty line.
// Assumes: rx_valid is a one-cycle byte strobe; synchronous active-low reset.
module wave_cmd_parser
    import wfp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              cmd_valid,
    output logic [2:0]        cmd_wave,
    output logic              cmd_err,
    output logic              freq_set,
    output logic [NUM_W-1:0]  freq_val,
    output logic              amp_set,
    output logic [NUM_W-1:0]  amp_val
);
    localparam int ACW = $clog2(N_ARGS + 1);

    pstate_e          st, st_n;
    logic [7:0]       c0, c0_n, c1, c1_n;
    logic [NUM_W-1:0] num, num_n, acc_next;
    logic [NUM_W-1:0] args [N_ARGS];
    logic [NUM_W-1:0] args_n [N_ARGS];
    logic [ACW-1:0]   argc, argc_n;
    logic             emit, bad;

    logic [7:0] up_ch;
    logic       is_digit, is_space, is_term;
    logic [3:0] digit;
    wave_e      code;
    logic       known;

    wfp_char_class u_cls (
        .ch(rx_data), .up_ch(up_ch), .is_digit(is_digit),
        .is_space(is_space), .is_term(is_term), .digit(digit)
    );

    wfp_mnem_decode u_dec (.c0(c0), .c1(c1), .code(code), .known(known));

    wfp_num_acc #(.W(NUM_W)) u_acc (.acc_in(num), .digit(digit), .acc_out(acc_next));

    // Next-state logic: walk through the fields of the line, one byte at a time.
    always_comb begin
        st_n   = st;
        c0_n   = c0;
        c1_n   = c1;
        num_n  = num;
        argc_n = argc;
        for (int i = 0; i < N_ARGS; i++) args_n[i] = args[i];
        emit = 1'b0;
        bad  = 1'b0;
        if (rx_valid) begin
            case (st)
                P_IDLE: begin
                    if (!is_term && !is_space) begin
                        c0_n   = up_ch;
                        argc_n = '0;
                        for (int i = 0; i < N_ARGS; i++) args_n[i] = '0;
                        st_n   = P_MN1;
                    end
                end
                P_MN1: begin
                    if (is_term) begin
                        emit = 1'b1; bad = 1'b1; st_n = P_IDLE;
                    end else if (is_space) begin
                        st_n = P_BAD;
                    end else begin
                        c1_n = up_ch; st_n = P_MN2;
                    end
                end
                P_MN2: begin
                    if (is_term) begin
                        emit = 1'b1; bad = !known; st_n = P_IDLE;
                    end else if (is_space) begin
                        st_n = known ? P_GAP : P_BAD;
                    end else begin
                        st_n = P_BAD;
                    end
                end
                P_GAP: begin
                    if (is_term) begin
                        emit = 1'b1; st_n = P_IDLE;
                    end else if (is_digit) begin
                        if (argc == ACW'(N_ARGS)) st_n = P_BAD;
                        else begin
                            num_n = NUM_W'(digit); st_n = P_NUM;
                        end
                    end else if (!is_space) begin
                        st_n = P_BAD;
                    end
                end
                P_NUM: begin
                    if (is_digit) begin
                        num_n = acc_next;
                    end else if (is_space || is_term) begin
                        for (int i = 0; i < N_ARGS; i++)
                            if (argc == ACW'(i)) args_n[i] = num;
                        argc_n = argc + 1'b1;
                        if (is_term) begin
                            emit = 1'b1; st_n = P_IDLE;
                        end else begin
                            st_n = P_GAP;
                        end
                    end else begin
                        st_n = P_BAD;
                    end
                end
                default: begin // P_BAD
                    if (is_term) begin
                        emit = 1'b1; bad = 1'b1; st_n = P_IDLE;
                    end
                end
            endcase
        end
    end

    // Parser state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= P_IDLE;
            c0   <= '0;
            c1   <= '0;
            num  <= '0;
            argc <= '0;
            for (int i = 0; i < N_ARGS; i++) args[i] <= '0;
        end else begin
            st   <= st_n;
            c0   <= c0_n;
            c1   <= c1_n;
            num  <= num_n;
            argc <= argc_n;
            for (int i = 0; i < N_ARGS; i++) args[i] <= args_n[i];
        end
    end

    // Command output registers: the strobe pulses, the fields hold until the next line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_wave  <= '0;
            cmd_err   <= 1'b0;
            freq_set  <= 1'b0;
            freq_val  <= '0;
            amp_set   <= 1'b0;
            amp_val   <= '0;
        end else begin
            cmd_valid <= emit;
            if (emit) begin
                cmd_wave <= bad ? W_BAD : code;
                cmd_err  <= bad;
                freq_set <= !bad && (argc_n >= ACW'(1));
                amp_set  <= !bad && (argc_n >= ACW'(2));
                freq_val <= (!bad && argc_n >= ACW'(1)) ? args_n[0] : '0;
                amp_val  <= (!bad && argc_n >= ACW'(2)) ? args_n[1] : '0;
            end
        end
    end

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R3
    AST_STROBE_AFTER_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(rx_valid && (rx_data == 8'h0D || rx_data == 8'h0A))); // R3
    AST_AMP_NEEDS_FREQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && amp_set) |-> freq_set); // R5
    AST_ERR_NO_PARAMS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_err) |-> (!freq_set && !amp_set && cmd_wave == 3'd7)); // R7
    AST_IDLE_AFTER_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (rx_data == 8'h0D || rx_data == 8'h0A)) |=> (st == P_IDLE)); // R11
endmodule

// File: tb/wave_cmd_parser_test.sv
// Bench: directed scenarios for the waveform command parser, one task each.
module wave_cmd_parser_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        cmd_valid, cmd_err, freq_set, amp_set;
    logic [2:0]  cmd_wave;
    logic [31:0] freq_val, amp_val;

    int checks = 0;
    int failures = 0;
    int strobes = 0;
    logic [2:0]  c_wave;
    logic        c_err, c_fs, c_as;
    logic [31:0] c_fv, c_av;

    wave_cmd_parser uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .cmd_valid(cmd_valid), .cmd_wave(cmd_wave), .cmd_err(cmd_err),
        .freq_set(freq_set), .freq_val(freq_val),
        .amp_set(amp_set), .amp_val(amp_val)
    );

    always #4 clk = ~clk;

    // Capture every command strobe.
    always @(posedge clk) begin
        if (rst_n && cmd_valid) begin
            strobes <= strobes + 1;
            c_wave <= cmd_wave; c_err <= cmd_err;
            c_fs <= freq_set; c_fv <= freq_val;
            c_as <= amp_set;  c_av <= amp_val;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send_byte(s[i]);
    endtask

    // Sends a line and checks the strobe count and the captured fields.
    task automatic line(input string req, input string s, input int n_exp,
                        input logic [2:0] w, input logic e, input logic fs,
                        input logic [31:0] fv, input logic as_, input logic [31:0] av);
        int base;
        base = strobes;
        send_str(s);
        repeat (3) @(negedge clk);
        chk(req, 32'(strobes - base), 32'(n_exp));
        if (n_exp > 0) begin
            chk(req, {29'd0, c_wave}, {29'd0, w});
            chk(req, {31'd0, c_err}, {31'd0, e});
            chk(req, {31'd0, c_fs}, {31'd0, fs});
            chk(req, c_fv, fv);
            chk(req, {31'd0, c_as}, {31'd0, as_});
            chk(req, c_av, av);
        end
    endtask

    task automatic t_reset;
        chk("R12 valid", {31'd0, cmd_valid}, 0);
        chk("R12 wave", {29'd0, cmd_wave}, 0);
        chk("R12 err", {31'd0, cmd_err}, 0);
        chk("R12 flags", {30'd0, freq_set, amp_set}, 0);
        chk("R12 vals", freq_val | amp_val, 0);
    endtask

    task automatic t_codes;
        line("R1 OF", "OF\r", 1, 3'd0, 0, 0, 0, 0, 0);
        line("R1 SQ", "SQ\r", 1, 3'd1, 0, 0, 0, 0, 0);
        line("R1 SI", "SI\r", 1, 3'd2, 0, 0, 0, 0, 0);
        line("R1 TR", "TR\r", 1, 3'd3, 0, 0, 0, 0, 0);
        line("R1 SA", "SA\r", 1, 3'd4, 0, 0, 0, 0, 0);
        line("R1 help", "??\n", 1, 3'd5, 0, 0, 0, 0, 0);
    endtask

    task automatic t_case;
        line("R2 lower", "sq\r", 1, 3'd1, 0, 0, 0, 0, 0);
        line("R2 mixed", "tR 12\n", 1, 3'd3, 0, 1, 12, 0, 0);
    endtask

    task automatic t_strobe;
        send_byte("S");
        @(negedge clk); rx_data = 8'h0D;   // not valid: must be ignored
        @(negedge clk); rx_data = "Q";
        @(negedge clk);
        chk("R3 ignored no strobe", {31'd0, cmd_valid}, 0);
        send_byte("A");
        send_byte(8'h0D);
        chk("R3 strobe high", {31'd0, cmd_valid}, 1);
        chk("R3 ignored bytes", {29'd0, cmd_wave}, 3'd4);
        @(negedge clk);
        chk("R3 strobe one cycle", {31'd0, cmd_valid}, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_empty;
        line("R4 empty", "\r", 0, 0, 0, 0, 0, 0, 0);
        line("R4 spaces", "    \n", 0, 0, 0, 0, 0, 0, 0);
        line("R4 crlf", "SI\r\n", 1, 3'd2, 0, 0, 0, 0, 0);
    endtask

    task automatic t_args;
        line("R5 freq", "SI 1000\r", 1, 3'd2, 0, 1, 1000, 0, 0);
        line("R5 both", "TR  440   123\r", 1, 3'd3, 0, 1, 440, 1, 123);
        line("R5 trailing", "SQ 0 65535  \n", 1, 3'd1, 0, 1, 0, 1, 65535);
        line("R5 lead spaces", "  OF\r", 1, 3'd0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_sat;
        line("R6 max", "SA 4294967295\r", 1, 3'd4, 0, 1, 32'hFFFFFFFF, 0, 0);
        line("R6 over", "SA 4294967296\r", 1, 3'd4, 0, 1, 32'hFFFFFFFF, 0, 0);
        line("R6 far over", "SA 7 99999999999\r", 1, 3'd4, 0, 1, 7, 1, 32'hFFFFFFFF);
    endtask

    task automatic t_unknown;
        line("R7 unknown", "XY 5\r", 1, 3'd7, 1, 0, 0, 0, 0);
        line("R7 unknown noarg", "SB\r", 1, 3'd7, 1, 0, 0, 0, 0);
    endtask

    task automatic t_bad_number;
        line("R8 digit mix", "SI 12a4\r", 1, 3'd7, 1, 0, 0, 0, 0);
        line("R8 not number", "SI x\r", 1, 3'd7, 1, 0, 0, 0, 0);
    endtask

    task automatic t_too_many;
        line("R9 three args", "SI 1 2 3\r", 1, 3'd7, 1, 0, 0, 0, 0);
    endtask

    task automatic t_length;
        line("R10 one char", "S\r", 1, 3'd7, 1, 0, 0, 0, 0);
        line("R10 three chars", "SQQ 1\r", 1, 3'd7, 1, 0, 0, 0, 0);
        line("R10 split", "S Q\r", 1, 3'd7, 1, 0, 0, 0, 0);
    endtask

    task automatic t_recover;
        line("R11 bad line", "QQ 9\r", 1, 3'd7, 1, 0, 0, 0, 0);
        line("R11 next line", "OF 7 3\r", 1, 3'd0, 0, 1, 7, 1, 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_codes;
        t_case;
        t_strobe;
        t_empty;
        t_args;
        t_sat;
        t_unknown;
        t_bad_number;
        t_too_many;
        t_length;
        t_recover;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule